// File: doc/BRIEF.md
# Line store controller

This block fills a single scan line of 16-bit words into a local word array. It also paces a DMA controller through an active-low request line. An external command decoder opens a line, which clears the write pointer and the recorded length. Words then arrive through either a processor store strobe or a DMA store strobe, and each accepted word goes to the next array slot. The serial send engine reads the array back through a registered read port. It uses the recorded length to know how many words make up the line.

When request pacing is enabled and not masked, opening a line pulls the request low. The request is released after the programmed count plus one words have been taken. A fill command lets a line of constant data be declared in place of writing it. The command records a length of its argument plus one words, raises a fixed-content flag and closes the line without touching the array.

Top module: `line_store_ctrl`

## Requirements
- R1: After reset, `dreq_n` is 1, `line_len` is 0, `mem_addr` is 0, `line_fixed` is 0 and the block is not accepting words.
- R2: A pulse on `open_line` sets `mem_addr` and `line_len` to 0 and `line_fixed` to 0 at the next clock edge, and the block starts accepting words.
- R3: While accepting, a cycle with `cpu_store` or `dma_store` high (both together count as one word) raises `mem_we`. It writes `store_data` at `mem_addr` and increments `mem_addr` and `line_len` by one at the clock edge.
- R4: Store strobes while the block is not accepting words leave `mem_addr`, `line_len` and the array unchanged, and `mem_we` stays 0.
- R5: At most DEPTH (320) words are stored. A store with `mem_addr` equal to 320 is discarded and leaves the array, the pointer and the length unchanged.
- R6: Opening a line with `dreq_enable` = 1 and `dreq_mask` = 0 drives `dreq_n` low from the next cycle.
- R7: With `dreq_words` = N at the open, `dreq_n` returns to 1 in the cycle after the (N+1)-th accepted word.
- R8: Opening a line with `dreq_mask` = 1 keeps `dreq_n` at 1 for the whole line.
- R9: `dreq_n` is 1 in any cycle in which `dreq_enable` is 0.
- R10: A `fill_line` pulse while accepting sets `line_len` to min(`fill_words`+1, 320) and `line_fixed` to 1. It writes no array word, releases `dreq_n` and stops word acceptance. A `fill_line` pulse while not accepting has no effect.
- R11: In one cycle, `open_line` takes priority over `fill_line`, which takes priority over a store.
- R12: `rd_data` presents the array word at `rd_addr` one clock after it is sampled, as it was before any write in that same edge.
- R13: A store discarded because the array is full releases `dreq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_store | input | 1 | Processor word store strobe |
| dma_store | input | 1 | DMA word store strobe |
| store_data | input | 16 | Word to store |
| open_line | input | 1 | Pulse: start a new line |
| fill_line | input | 1 | Pulse: declare a constant-data line |
| fill_words | input | 9 | Fill length minus one, in words |
| dreq_enable | input | 1 | Request pacing enabled |
| dreq_words | input | 9 | Request length minus one, in words |
| dreq_mask | input | 1 | Suppress the request for this line |
| rd_addr | input | 9 | Read port address |
| rd_data | output | 16 | Read port data, one cycle latency |
| mem_we | output | 1 | Array write enable this cycle |
| mem_addr | output | 9 | Array write pointer |
| line_len | output | 9 | Recorded line length in words |
| line_fixed | output | 1 | Line holds constant fill data |
| dreq_n | output | 1 | Active-low DMA request |

## Verification
Short lines of mixed processor and DMA strobes are read back in full, which separates a wrong slot from a skipped or doubled increment. Request windows with small counts show an off-by-one in the release against the plus-one rule. A count larger than the array shows the full-array release instead. Masked, disabled and mid-line disable patterns show the request gating apart from the count. Simultaneous open, fill and store pulses, a long random mix of all commands and fills at and beyond 320 words cover the priority and clipping corners.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int LSC_DW    = 16;
    localparam int LSC_DEPTH = 320;
    localparam int LSC_CNTW  = 9;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_OPEN,
        OP_FILL,
        OP_STORE,
        OP_DROP
    } lsc_op_e;
endpackage

// File: rtl/lsc_op_decode.sv
module lsc_op_decode
    import lsc_pkg::*;
(
    input  logic    open_i,
    input  logic    fill_i,
    input  logic    store_i,
    input  logic    wmode_i,
    input  logic    full_i,
    output lsc_op_e op_o
);
    always_comb begin
        op_o = OP_IDLE;
        if (open_i) begin
            op_o = OP_OPEN;
        end else if (fill_i && wmode_i) begin
            op_o = OP_FILL;
        end else if (store_i && wmode_i) begin
            op_o = full_i ? OP_DROP : OP_STORE;
        end
    end
endmodule

// File: rtl/lsc_line_ptr.sv
module lsc_line_ptr
    import lsc_pkg::*;
#(
    parameter int DEPTH = LSC_DEPTH,
    parameter int CNTW  = LSC_CNTW,
    localparam int AW   = $clog2(DEPTH + 1),
    localparam int SW   = ((CNTW + 1) > (AW + 1)) ? (CNTW + 1) : (AW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lsc_op_e         op_i,
    input  logic [CNTW-1:0] fill_words_i,
    output logic            wmode_o,
    output logic            full_o,
    output logic [AW-1:0]   ptr_o,
    output logic [AW-1:0]   len_o,
    output logic            fixed_o
);
    typedef struct packed {
        logic          wmode;
        logic [AW-1:0] ptr;
        logic [AW-1:0] len;
        logic          fixed;
    } ptr_state_t;

    ptr_state_t s_d, s_q;
    logic [SW-1:0] fill_sum;
    logic [AW-1:0] fill_len;

    always_comb begin
        fill_sum = SW'(fill_words_i) + SW'(1);
        fill_len = (fill_sum > SW'(DEPTH)) ? AW'(DEPTH) : AW'(fill_sum);
        s_d = s_q;
        unique case (op_i)
            OP_OPEN: begin
                s_d.wmode = 1'b1;
                s_d.ptr   = '0;
                s_d.len   = '0;
                s_d.fixed = 1'b0;
            end
            OP_FILL: begin
                s_d.wmode = 1'b0;
                s_d.len   = fill_len;
                s_d.fixed = 1'b1;
            end
            OP_STORE: begin
                s_d.ptr = s_q.ptr + 1'b1;
                s_d.len = s_q.len + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wmode_o = s_q.wmode;
    assign full_o  = (s_q.ptr == AW'(DEPTH));
    assign ptr_o   = s_q.ptr;
    assign len_o   = s_q.len;
    assign fixed_o = s_q.fixed;

    // R5
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ptr <= AW'(DEPTH)) && (s_q.len <= AW'(DEPTH)));
    // R3
    store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STORE) |=> (s_q.ptr == $past(s_q.ptr) + 1'b1));
    // R2
    open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_OPEN) |=> (s_q.ptr == '0 && s_q.len == '0 && s_q.wmode && !s_q.fixed));
    // R10
    fill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FILL) |=> (s_q.fixed && !s_q.wmode && $stable(s_q.ptr)));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.wmode && op_i != OP_OPEN) |=> ($stable(s_q.len) && $stable(s_q.ptr)));
endmodule

// File: rtl/lsc_dreq_gen.sv
module lsc_dreq_gen
    import lsc_pkg::*;
#(
    parameter int CNTW = LSC_CNTW,
    localparam int CW  = CNTW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lsc_op_e         op_i,
    input  logic            enable_i,
    input  logic            mask_i,
    input  logic [CNTW-1:0] words_i,
    output logic            dreq_n_o
);
    typedef struct packed {
        logic          low;
        logic [CW-1:0] left;
    } dreq_state_t;

    dreq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (op_i)
            OP_OPEN: begin
                s_d.low  = enable_i && !mask_i;
                s_d.left = CW'(words_i) + CW'(1);
            end
            OP_STORE: begin
                if (s_q.low) begin
                    s_d.left = s_q.left - 1'b1;
                    if (s_q.left == CW'(1)) s_d.low = 1'b0;
                end
            end
            OP_FILL, OP_DROP: begin
                s_d.low = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dreq_n_o = !(s_q.low && enable_i);

    // R8
    mask_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_OPEN && mask_i) |=> dreq_n_o);
    // R6
    open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_OPEN && enable_i && !mask_i) |=> (!enable_i || !dreq_n_o));
    // R13
    drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DROP || op_i == OP_FILL) |=> dreq_n_o);
    // R7
    left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.low |-> (s_q.left != '0));
endmodule

// File: rtl/lsc_line_ram.sv
module lsc_line_ram
    import lsc_pkg::*;
#(
    parameter int DW    = LSC_DW,
    parameter int DEPTH = LSC_DEPTH,
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i && (waddr_i < AW'(DEPTH))) mem_q[waddr_i] <= wdata_i;
        rdata_q <= (raddr_i < AW'(DEPTH)) ? mem_q[raddr_i] : '0;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/line_store_ctrl.sv
module line_store_ctrl
    import lsc_pkg::*;
#(
    parameter int DW    = LSC_DW,
    parameter int DEPTH = LSC_DEPTH,
    parameter int CNTW  = LSC_CNTW,
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_store,
    input  logic            dma_store,
    input  logic [DW-1:0]   store_data,
    input  logic            open_line,
    input  logic            fill_line,
    input  logic [CNTW-1:0] fill_words,
    input  logic            dreq_enable,
    input  logic [CNTW-1:0] dreq_words,
    input  logic            dreq_mask,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [AW-1:0]   line_len,
    output logic            line_fixed,
    output logic            dreq_n
);
    lsc_op_e op;
    logic    wmode, full;

    lsc_op_decode u_dec (
        .open_i  (open_line),
        .fill_i  (fill_line),
        .store_i (cpu_store || dma_store),
        .wmode_i (wmode),
        .full_i  (full),
        .op_o    (op)
    );

    lsc_line_ptr #(.DEPTH(DEPTH), .CNTW(CNTW)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .fill_words_i (fill_words),
        .wmode_o      (wmode),
        .full_o       (full),
        .ptr_o        (mem_addr),
        .len_o        (line_len),
        .fixed_o      (line_fixed)
    );

    lsc_dreq_gen #(.CNTW(CNTW)) u_dreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .enable_i (dreq_enable),
        .mask_i   (dreq_mask),
        .words_i  (dreq_words),
        .dreq_n_o (dreq_n)
    );

    assign mem_we = (op == OP_STORE);

    lsc_line_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_addr),
        .wdata_i (store_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    // R11
    open_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_line && fill_line) |=> (!line_fixed && line_len == '0));
    // R10
    fill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_line |-> !mem_we);
endmodule

// File: tb/test_line_store_ctrl.sv
module test_line_store_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 320;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_store = 0, dma_store = 0, open_line = 0, fill_line = 0;
    logic [15:0] store_data = '0;
    logic [8:0] fill_words = '0, dreq_words = '0, rd_addr = '0;
    logic dreq_enable = 0, dreq_mask = 0;
    logic [15:0] rd_data;
    logic mem_we, line_fixed, dreq_n;
    logic [8:0] mem_addr, line_len;

    line_store_ctrl i_line_store_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_store(cpu_store), .dma_store(dma_store),
        .store_data(store_data), .open_line(open_line), .fill_line(fill_line),
        .fill_words(fill_words), .dreq_enable(dreq_enable), .dreq_words(dreq_words),
        .dreq_mask(dreq_mask), .rd_addr(rd_addr), .rd_data(rd_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .line_len(line_len), .line_fixed(line_fixed), .dreq_n(dreq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    // behavioural reference
    int m_mem[DEPTH];
    bit m_known[DEPTH];
    bit m_wm = 0, m_fix = 0, m_low = 0;
    int m_ptr = 0, m_len = 0, m_left = 0;
    int m_rd = 0;
    bit m_rd_known = 0;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit st;
        int a;
        st = cpu_store || dma_store;
        a = int'(rd_addr);
        m_rd_known = (a < DEPTH) && m_known[a];
        m_rd = (a < DEPTH) ? m_mem[a] : 0;
        if (open_line) begin
            m_wm = 1; m_ptr = 0; m_len = 0; m_fix = 0;
            m_low = dreq_enable && !dreq_mask;
            m_left = int'(dreq_words) + 1;
        end else if (fill_line && m_wm) begin
            m_wm = 0; m_fix = 1; m_low = 0;
            m_len = (int'(fill_words) + 1 > DEPTH) ? DEPTH : int'(fill_words) + 1;
        end else if (st && m_wm) begin
            if (m_ptr < DEPTH) begin
                m_mem[m_ptr] = int'(store_data);
                m_known[m_ptr] = 1;
                m_ptr++; m_len++;
                if (m_low) begin
                    m_left--;
                    if (m_left == 0) m_low = 0;
                end
            end else begin
                m_low = 0;
            end
        end
    endtask

    task automatic compare_all();
        check("R3 mem_addr", int'(mem_addr), m_ptr);
        check("R3 line_len", int'(line_len), m_len);
        check("R10 line_fixed", int'(line_fixed), int'(m_fix));
        check("R7 dreq_n", int'(dreq_n), int'(!(m_low && dreq_enable)));
        if (m_rd_known) check("R12 rd_data", int'(rd_data), m_rd);
    endtask

    // inputs already driven after a falling edge
    task automatic step();
        bit exp_we;
        #1;
        exp_we = !open_line && !(fill_line && m_wm) && m_wm &&
                 (cpu_store || dma_store) && (m_ptr < DEPTH);
        check("R3 mem_we", int'(mem_we), int'(exp_we));
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        cpu_store = 0; dma_store = 0; open_line = 0; fill_line = 0;
    endtask

    task automatic open_cmd(int n, bit en, bit msk);
        idle_inputs();
        dreq_words = 9'(n); dreq_enable = en; dreq_mask = msk; open_line = 1;
        step();
        open_line = 0;
    endtask

    task automatic store_word(int v, bit via_dma);
        idle_inputs();
        store_data = 16'(v); cpu_store = !via_dma; dma_store = via_dma;
        step();
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_known[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 dreq_n", int'(dreq_n), 1);
        check("R1 line_len", int'(line_len), 0);
        check("R1 mem_addr", int'(mem_addr), 0);
        check("R1 line_fixed", int'(line_fixed), 0);
        rst_n = 1;
        @(negedge clk);

        // R4 stores before any open are ignored
        store_word(16'h1111, 0);
        store_word(16'h2222, 1);
        check("R4 len unchanged", int'(line_len), 0);
        check("R4 addr unchanged", int'(mem_addr), 0);

        // R6 R7 request window N=4 -> 5 words
        open_cmd(4, 1, 0);
        check("R2 addr cleared", int'(mem_addr), 0);
        check("R6 dreq low after open", int'(dreq_n), 0);
        for (int i = 0; i < 5; i++) begin
            check("R7 dreq still low", int'(dreq_n), 0);
            store_word(16'hA000 + i, i[0]);
        end
        check("R7 dreq released after N+1", int'(dreq_n), 1);
        store_word(16'hA005, 0);
        idle_inputs(); cpu_store = 1; dma_store = 1; store_data = 16'hA006;
        step(); idle_inputs();
        check("R3 both strobes one word", int'(line_len), 7);

        // R12 read back
        for (int i = 0; i < 7; i++) begin rd_addr = 9'(i); step(); end
        rd_addr = 9'd3; step();
        check("R12 word 3", int'(rd_data), 16'hA003);

        // R8 masked open
        open_cmd(2, 1, 1);
        check("R8 masked dreq high", int'(dreq_n), 1);
        store_word(16'hB000, 1);
        check("R8 still high", int'(dreq_n), 1);

        // R9 enable drop mid-line
        open_cmd(10, 1, 0);
        check("R6 low", int'(dreq_n), 0);
        dreq_enable = 0; step();
        check("R9 high while disabled", int'(dreq_n), 1);
        dreq_enable = 1; step();

        // R11 priority
        idle_inputs(); open_line = 1; fill_line = 1; cpu_store = 1; fill_words = 9'd5;
        step(); idle_inputs();
        check("R11 open wins", int'(line_fixed), 0);
        check("R11 open wins len", int'(line_len), 0);
        idle_inputs(); fill_line = 1; cpu_store = 1; store_data = 16'hDEAD; fill_words = 9'd9;
        step(); idle_inputs();
        check("R10 fill len", int'(line_len), 10);
        check("R11 fill beats store", int'(mem_addr), 0);
        check("R10 fill releases dreq", int'(dreq_n), 1);
        // R10 fill when closed ignored, stores ignored
        fill_line = 1; fill_words = 9'd2; step(); idle_inputs();
        check("R10 closed fill ignored", int'(line_len), 10);
        store_word(16'h5555, 0);
        check("R4 closed store ignored", int'(mem_addr), 0);
        open_cmd(0, 0, 0);
        fill_line = 1; fill_words = 9'd400; step(); idle_inputs();
        check("R10 fill clipped", int'(line_len), DEPTH);

        // R5 R13 full array with long request
        open_cmd(400, 1, 0);
        for (int i = 0; i < DEPTH; i++) store_word(16'hC000 + i, i[0]);
        check("R5 full len", int'(line_len), DEPTH);
        check("R13 dreq low at full", int'(dreq_n), 0);
        store_word(16'hFFFF, 1);
        check("R13 dropped store releases", int'(dreq_n), 1);
        check("R5 no growth", int'(line_len), DEPTH);
        rd_addr = 9'd319; step(); step();
        check("R5 last word kept", int'(rd_data), 16'hC000 + 319);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            idle_inputs();
            if ($urandom_range(0, 99) < 2) begin
                open_line = 1;
                dreq_words = 9'($urandom_range(0, 20));
                dreq_mask = ($urandom_range(0, 3) == 0);
            end
            if ($urandom_range(0, 199) < 1) begin
                fill_line = 1; fill_words = 9'($urandom_range(0, 511));
            end
            cpu_store = ($urandom_range(0, 2) == 0);
            dma_store = ($urandom_range(0, 2) == 0);
            store_data = 16'($urandom);
            if ($urandom_range(0, 49) == 0) dreq_enable = !dreq_enable;
            rd_addr = 9'($urandom_range(0, DEPTH - 1));
            step();
        end
        idle_inputs();
        finish_run();
    end
endmodule